// File: doc/BRIEF.md
# Program Fetch Bus Router

This block takes one 16-bit program fetch request at a time from a processor core and routes it to one of two places: a small on-chip program store, or an external memory reached over a narrow multiplexed bus. A strap input selects the split. With the strap high, the lowest 4 KiB of the fetch space is served on chip and everything above it goes off chip. With the strap low, every fetch goes off chip, so a board can replace the on-chip code entirely.

An external fetch runs a fixed sequence of phases. First a latch strobe is raised while one shared byte lane carries the low address. Next the strobe falls so that an external latch holds that address. Then the lane is released and an active-low enable lets the external memory drive its byte back onto the lane. A separate output carries the high address byte for the whole cycle. Each phase lasts a parameterised number of clocks. An on-chip fetch completes in a single cycle. Both paths return the fetched byte to the core with a one-cycle valid pulse.

Top module: `pfetch_bus_if`

## Requirements
- R1: With the strap high, an accepted request whose address is below 0x1000 pulses the store read for that cycle with the store address equal to address bits 11:0. The response valid is high on the next cycle and carries the store byte. The external strobe and enable stay inactive.
- R2: An accepted request goes to the external bus when the strap is high and the address is 0x1000 or above. It also goes to the external bus when the strap is low, whatever the address. In both cases the store read stays low.
- R3: After reset and while idle, request ready is 1, the latch strobe is 0, the active-low enable is 1, the lane output enable is 0 and the response valid is 0.
- R4: The address phase covers the PHASE_CLKS cycles that follow acceptance. During it the strobe is 1, the lane is driven (output enable 1) with address bits 7:0, and the enable is 1.
- R5: The hold phase covers the next PHASE_CLKS cycles. During it the strobe is 0, the lane still drives address bits 7:0, and the enable is still 1.
- R6: The read phase covers the next PHASE_CLKS cycles. During it the enable is 0 and the lane is released (output enable 0). The lane input is captured on the clock that ends this phase.
- R7: The high address output equals address bits 15:8 of the accepted request for every cycle of the external fetch.
- R8: On the cycle after the read phase, response valid is 1 for exactly one cycle and carries the captured byte. On that same cycle the enable is 1 and request ready is 1 again.
- R9: While an external fetch runs, request ready is 0. Changes on the request inputs or on the strap do not alter the running cycle's outputs and do not start another fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ea_strap | input | 1 | 1: low 4 KiB on chip; 0: all fetches external |
| req_valid | input | 1 | Fetch request present |
| req_addr | input | 16 | Fetch address |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| rsp_valid | output | 1 | One-cycle pulse, fetched byte valid |
| rsp_data | output | 8 | Fetched byte |
| int_rd | output | 1 | On-chip store read strobe |
| int_addr | output | 12 | On-chip store address |
| int_rdata | input | 8 | On-chip store byte, same cycle as int_rd |
| ext_lo_out | output | 8 | Low address byte driven onto the shared lane |
| ext_lo_oe | output | 1 | Lane output enable |
| ext_lo_in | input | 8 | Byte read back from the shared lane |
| ext_hi | output | 8 | High address byte |
| ext_ale | output | 1 | Address latch strobe, active high |
| ext_psen_n | output | 1 | External program-store enable, active low |

## Verification
A wrong phase state or phase counter shows up at once on the pins. The strobe, lane enable and store enable take the wrong pattern on the first cycle of a misplaced phase, and a wrong phase length moves the response pulse by whole phases. A bad routing decision is visible in the same cycle as acceptance, because the store read either fires or stays low there. A capture taken from the wrong cycle or the wrong source appears on the very next cycle as a wrong response byte.

// File: rtl/pfetch_pkg.sv
// Shared types for the program fetch bus router.
// Assumes: one external fetch in flight at a time.
package pfetch_pkg;

    // Phases of an external fetch, in bus order.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_HOLD = 2'd2,
        PH_READ = 2'd3
    } ph_e;

endpackage

// File: rtl/pfetch_decode.sv
// Decides whether a fetch address is served by the on-chip store.
// Assumes: the on-chip window starts at address zero and spans 2**INT_AW bytes.
module pfetch_decode #(
    parameter int ADDR_W = 16,
    parameter int INT_AW = 12
) (
    input  logic              strap,
    input  logic [ADDR_W-1:0] addr,
    output logic              is_int
);

    generate
        if (INT_AW >= ADDR_W) begin : g_all_int
            // Whole space on chip when strapped.
            always_comb is_int = strap;
        end else if (INT_AW == 0) begin : g_no_int
            // No on-chip window.
            always_comb is_int = 1'b0;
        end else begin : g_window
            localparam int HI_W = ADDR_W - INT_AW;
            // On chip only when strapped and upper address bits are zero.
            always_comb is_int = strap && (addr[ADDR_W-1:INT_AW] == {HI_W{1'b0}});
        end
    endgenerate

endmodule

// File: rtl/pfetch_ext_seq.sv
// Sequences one external fetch: address, hold, read phases.
// Assumes: start only pulses while busy is low; lane input is valid on the
// last clock of the read phase.
module pfetch_ext_seq
    import pfetch_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int PHASE_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              busy,
    output logic              finishing,
    output logic              ale,
    output logic              lo_oe,
    output logic              psen_n,
    output logic [DATA_W-1:0] lo_out,
    output logic [ADDR_W-DATA_W-1:0] hi
);

    localparam int CW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASE_CLKS - 1);

    ph_e               st;
    logic [CW-1:0]     cnt;
    logic [ADDR_W-1:0] addr_q;

    // Phase state, per-phase clock counter and captured address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= PH_IDLE;
            cnt    <= '0;
            addr_q <= '0;
        end else begin
            case (st)
                PH_IDLE: begin
                    if (start) begin
                        st     <= PH_ADDR;
                        cnt    <= '0;
                        addr_q <= start_addr;
                    end
                end
                PH_ADDR, PH_HOLD, PH_READ: begin
                    if (cnt == LAST) begin
                        cnt <= '0;
                        case (st)
                            PH_ADDR: st <= PH_HOLD;
                            PH_HOLD: st <= PH_READ;
                            default: st <= PH_IDLE;
                        endcase
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= PH_IDLE;
            endcase
        end
    end

    // Bus pin levels decoded from the registered phase.
    always_comb begin
        busy      = (st != PH_IDLE);
        finishing = (st == PH_READ) && (cnt == LAST);
        ale       = (st == PH_ADDR);
        lo_oe     = (st == PH_ADDR) || (st == PH_HOLD);
        psen_n    = (st != PH_READ);
        lo_out    = addr_q[DATA_W-1:0];
        hi        = addr_q[ADDR_W-1:DATA_W];
    end

    AST_STROBE_WITH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (lo_oe && psen_n)); // R4
    AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (lo_oe && psen_n)); // R5
    AST_LANE_FREE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n |-> !lo_oe); // R6
    AST_HI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(hi)); // R7
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finishing) |=> busy); // R9
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R4

endmodule

// File: rtl/pfetch_resp.sv
// Registers the fetched byte and its one-cycle valid pulse.
// Assumes: internal fire and external finishing never coincide.
module pfetch_resp #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_fire,
    input  logic [DATA_W-1:0] int_byte,
    input  logic              ext_finishing,
    input  logic [DATA_W-1:0] ext_byte,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    // Capture the byte from whichever source completes this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= int_fire || ext_finishing;
            if (int_fire) begin
                rsp_data <= int_byte;
            end else if (ext_finishing) begin
                rsp_data <= ext_byte;
            end
        end
    end

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_fire && ext_finishing)); // R8
    AST_EXT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_finishing |=> rsp_valid); // R8

endmodule

// File: rtl/pfetch_bus_if.sv
// Routes program fetches to the on-chip store or the external multiplexed bus.
// Assumes: the on-chip store answers combinationally in the read cycle.
module pfetch_bus_if #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int INT_AW     = 12,
    parameter int PHASE_CLKS = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ea_strap,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    output logic                     req_ready,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_data,
    output logic                     int_rd,
    output logic [INT_AW-1:0]        int_addr,
    input  logic [DATA_W-1:0]        int_rdata,
    output logic [DATA_W-1:0]        ext_lo_out,
    output logic                     ext_lo_oe,
    input  logic [DATA_W-1:0]        ext_lo_in,
    output logic [ADDR_W-DATA_W-1:0] ext_hi,
    output logic                     ext_ale,
    output logic                     ext_psen_n
);

    logic is_int;
    logic busy;
    logic finishing;
    logic fire;
    logic ext_start;

    pfetch_decode #(.ADDR_W(ADDR_W), .INT_AW(INT_AW)) u_decode (
        .strap  (ea_strap),
        .addr   (req_addr),
        .is_int (is_int)
    );

    // Acceptance and routing of the current request.
    always_comb begin
        req_ready = !busy;
        fire      = req_valid && req_ready;
        int_rd    = fire && is_int;
        ext_start = fire && !is_int;
        int_addr  = req_addr[INT_AW-1:0];
    end

    pfetch_ext_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PHASE_CLKS(PHASE_CLKS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (ext_start),
        .start_addr (req_addr),
        .busy       (busy),
        .finishing  (finishing),
        .ale        (ext_ale),
        .lo_oe      (ext_lo_oe),
        .psen_n     (ext_psen_n),
        .lo_out     (ext_lo_out),
        .hi         (ext_hi)
    );

    pfetch_resp #(.DATA_W(DATA_W)) u_resp (
        .clk           (clk),
        .rst_n         (rst_n),
        .int_fire      (int_rd),
        .int_byte      (int_rdata),
        .ext_finishing (finishing),
        .ext_byte      (ext_lo_in),
        .rsp_valid     (rsp_valid),
        .rsp_data      (rsp_data)
    );

    AST_INT_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        int_rd |-> (ext_psen_n && !ext_ale)); // R1
    AST_INT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        int_rd |=> rsp_valid); // R1
    AST_STRAP_LOW_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !ea_strap) |-> !int_rd); // R2
    AST_EXT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        ext_start |=> (ext_ale && !req_ready)); // R2

endmodule

// File: tb/sim_pfetch_bus_if.sv
`timescale 1ns/1ps
module sim_pfetch_bus_if;

    localparam int P = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ea_strap = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic        int_rd;
    logic [11:0] int_addr;
    logic [7:0]  int_rdata;
    logic [7:0]  ext_lo_out;
    logic        ext_lo_oe;
    logic [7:0]  ext_lo_in = '0;
    logic [7:0]  ext_hi;
    logic        ext_ale;
    logic        ext_psen_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // Behavioural on-chip store contents.
    function automatic logic [7:0] rom_byte(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h3C;
    endfunction

    assign int_rdata = int_rd ? rom_byte(int_addr) : 8'h00;

    pfetch_bus_if #(.PHASE_CLKS(P)) u0 (
        .clk(clk), .rst_n(rst_n), .ea_strap(ea_strap),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .int_rd(int_rd), .int_addr(int_addr), .int_rdata(int_rdata),
        .ext_lo_out(ext_lo_out), .ext_lo_oe(ext_lo_oe), .ext_lo_in(ext_lo_in),
        .ext_hi(ext_hi), .ext_ale(ext_ale), .ext_psen_n(ext_psen_n)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic t_reset();
        chk(16'(req_ready), 16'd1, "R3 ready");
        chk(16'(ext_ale), 16'd0, "R3 ale");
        chk(16'(ext_psen_n), 16'd1, "R3 psen_n");
        chk(16'(ext_lo_oe), 16'd0, "R3 lane oe");
        chk(16'(rsp_valid), 16'd0, "R3 rsp_valid");
    endtask

    // One internal fetch, optionally followed directly by a second.
    task automatic t_int(input logic [15:0] a, input logic [15:0] b, input bit two);
        ea_strap  = 1'b1;
        req_valid = 1'b1;
        req_addr  = a;
        #1;
        chk(16'(int_rd), 16'd1, "R1 int_rd");
        chk(16'(int_addr), 16'(a[11:0]), "R1 int_addr");
        chk(16'(ext_ale), 16'd0, "R1 ale quiet");
        @(negedge clk);
        if (two) begin
            req_addr = b;
            #1;
            chk(16'(int_rd), 16'd1, "R1 back-to-back int_rd");
        end else begin
            req_valid = 1'b0;
        end
        chk(16'(rsp_valid), 16'd1, "R1 rsp_valid");
        chk(16'(rsp_data), 16'(rom_byte(a[11:0])), "R1 rsp_data");
        chk(16'(ext_psen_n), 16'd1, "R1 psen_n quiet");
        @(negedge clk);
        req_valid = 1'b0;
        if (two) begin
            chk(16'(rsp_valid), 16'd1, "R1 second rsp_valid");
            chk(16'(rsp_data), 16'(rom_byte(b[11:0])), "R1 second rsp_data");
            @(negedge clk);
        end
        chk(16'(rsp_valid), 16'd0, "R1 pulse ends");
    endtask

    // One external fetch; disturbs the request inputs while it runs.
    task automatic t_ext(input logic [15:0] a, input logic [7:0] d, input logic strap);
        ea_strap  = strap;
        req_valid = 1'b1;
        req_addr  = a;
        #1;
        chk(16'(int_rd), 16'd0, "R2 no store read");
        @(negedge clk);
        ea_strap = ~strap;
        req_addr = ~a;
        for (int i = 0; i < P; i++) begin
            #1;
            chk(16'(ext_ale), 16'd1, "R4 ale");
            chk(16'(ext_lo_oe), 16'd1, "R4 lane oe");
            chk(16'(ext_lo_out), 16'(a[7:0]), "R4 lane addr");
            chk(16'(ext_psen_n), 16'd1, "R4 psen_n");
            chk(16'(ext_hi), 16'(a[15:8]), "R7 hi addr");
            chk(16'(req_ready), 16'd0, "R9 ready low");
            chk(16'(int_rd), 16'd0, "R9 no new fetch");
            @(negedge clk);
        end
        for (int i = 0; i < P; i++) begin
            chk(16'(ext_ale), 16'd0, "R5 ale");
            chk(16'(ext_lo_oe), 16'd1, "R5 lane oe");
            chk(16'(ext_lo_out), 16'(a[7:0]), "R5 lane addr");
            chk(16'(ext_psen_n), 16'd1, "R5 psen_n");
            chk(16'(ext_hi), 16'(a[15:8]), "R7 hi addr");
            @(negedge clk);
        end
        req_valid = 1'b0;
        ext_lo_in = d;
        for (int i = 0; i < P; i++) begin
            chk(16'(ext_psen_n), 16'd0, "R6 psen_n");
            chk(16'(ext_lo_oe), 16'd0, "R6 lane free");
            chk(16'(ext_ale), 16'd0, "R6 ale");
            chk(16'(ext_hi), 16'(a[15:8]), "R7 hi addr");
            chk(16'(rsp_valid), 16'd0, "R8 no early rsp");
            @(negedge clk);
        end
        ext_lo_in = ~d;
        chk(16'(rsp_valid), 16'd1, "R8 rsp_valid");
        chk(16'(rsp_data), 16'(d), "R8 rsp_data");
        chk(16'(ext_psen_n), 16'd1, "R8 psen_n off");
        chk(16'(req_ready), 16'd1, "R8 ready");
        @(negedge clk);
        chk(16'(rsp_valid), 16'd0, "R8 pulse ends");
        chk(16'(ext_ale), 16'd0, "R9 no second cycle");
        ea_strap = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        @(negedge clk);
        t_int(16'h0000, 16'h0000, 1'b0);
        t_int(16'h0FFF, 16'h0000, 1'b0);
        t_int(16'h0123, 16'h0124, 1'b1);
        t_ext(16'h1000, 8'hA5, 1'b1);
        t_ext(16'hABCD, 8'h5A, 1'b1);
        t_ext(16'h0005, 8'hC3, 1'b0);
        t_ext(16'h0FFF, 8'h00, 1'b0);
        t_ext(16'hFFFF, 8'hFF, 1'b0);
        t_int(16'h0800, 16'h0000, 1'b0);
        t_reset();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule